// File: doc/BRIEF.md
# Enable-latched fuse PROM read controller

This block is a cycle-level model of a one-time-programmable read-only memory with a multiplexed-bus-friendly read protocol. An access starts when the active-low chip enable goes from high to low. On that clock edge the block stores the address bus in an internal register. From then on the external address lines are free to carry other traffic, and the read in progress is unaffected. The selected word appears on an 8-bit data output a fixed number of clock cycles later. An output-enable input gates it, as does a drive-enable output that stands in for a tri-state buffer. When chip enable is high, the block is disabled and drives nothing, whatever the output-enable level.

The storage array is organised as rows of bit groups. The upper address field picks a row. The lower field picks one column inside each of the per-bit column groups. Every cell starts at zero. A programming port can set any single cell to one, and nothing can set a cell back to zero. The default geometry is 16 rows by 8 columns per group (128 words, 7 address bits), which keeps elaboration small. The full-size configuration, ROW_BITS=8 and COL_BITS=5, gives 256 rows by 256 columns and 8192 words with a 13-bit address.

Top module: `latched_prom`

## Requirements
- R1: While rst_n is low, dout_drive and dout_valid are 0 and dout is all zeros.
- R2: The address is captured only on the first clock edge that sees ce_n low after ce_n was sampled high. Changes on addr_in after that edge do not alter the word being read.
- R3: With ce_n low and oe_n low after a capture, dout_drive is 1. Once data is ready, dout_valid is 1 and dout carries the addressed word.
- R4: With ce_n low and oe_n high, dout_drive and dout_valid are 0 and dout is zero. The latched word returns when oe_n goes low again.
- R5: With ce_n high, dout_drive and dout_valid are 0 for both levels of oe_n.
- R6: While ce_n stays low, no new address is accepted. This includes ce_n held low from reset, which produces no access. Reading a new address requires ce_n to be sampled high and then low again.
- R7: Every cell reads 0 until it is programmed. A programmed cell reads 1, and later programming of other cells never clears it.
- R8: A program request (pgm_req) changes the array only when pgm_mode is 1 and ce_n is 1 at the same clock edge. Otherwise it is ignored.
- R9: dout_valid is 0 for the LAT clock edges that follow the capture edge counted from it (default LAT=2), and becomes 1 after the LAT-th edge after capture.
- R10: Word address a maps to row a[AW-1:COL_BITS] and column a[COL_BITS-1:0]. pgm_bit = k sets bit k of the word at pgm_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; a falling edge starts a read |
| oe_n | input | 1 | Active-low output enable |
| addr_in | input | AW (7) | Read address, captured on the enable falling edge |
| pgm_mode | input | 1 | Programming mode select |
| pgm_req | input | 1 | Request to set one cell |
| pgm_addr | input | AW (7) | Word address of the cell to set |
| pgm_bit | input | $clog2(DW) (3) | Bit index of the cell to set |
| dout | output | DW (8) | Read data, zero when not valid |
| dout_drive | output | 1 | Output buffer drive enable (tri-state stand-in) |
| dout_valid | output | 1 | Read data on dout is valid |

## Verification
On every cycle, the assertions check the output truth table: no drive while disabled or while the output is held off, and valid only while driving. They also check that the latched address holds between captures, that no valid data appears on the cycle after a capture, that cells of the read row never drop from one to zero, and that the read row is frozen when programming is not permitted. Other behaviour can only be shown by the bench's scenarios, each compared against a word-level reference image. These are the exact latency count, the correct word under the row and column mapping, the ignoring of address traffic after the latching edge, the rejection of held-low enable as a new access, and the return of the same word after output enable toggles.

// File: rtl/latched_prom_pkg.sv
package latched_prom_pkg;

  // Output bus state derived from the enable pins and the access state
  typedef enum logic [1:0] {
    BUS_OFF   = 2'd0,   // device disabled or no access open
    BUS_HOLD  = 2'd1,   // enabled but output held off
    BUS_DRIVE = 2'd2    // enabled and driving
  } bus_mode_e;

  function automatic bus_mode_e decode_bus(input logic ce_n, input logic oe_n,
                                           input logic open_access);
    if (ce_n || !open_access) return BUS_OFF;
    if (oe_n)                 return BUS_HOLD;
    return BUS_DRIVE;
  endfunction

endpackage

// File: rtl/lp_edge_latch.sv
module lp_edge_latch #(
  parameter int AW  = 7,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr_in,
  output logic          cap,
  output logic [AW-1:0] addr_q,
  output logic          active,
  output logic          ready
);
  localparam int CW = $clog2(LAT + 1);

  logic          ce_hi_q;
  logic          act_d, act_q;
  logic [CW-1:0] cnt_d, cnt_q;

  // falling edge of enable as seen by the clock; reset state counts as "low"
  assign cap = ce_hi_q & ~ce_n;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (cap) begin
      act_d = 1'b1;
      cnt_d = CW'(LAT);
    end else if (ce_n) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_hi_q <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ce_hi_q <= ce_n;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (cap) addr_q <= addr_in;
  end

  assign active = act_q;
  assign ready  = act_q & (cnt_q == '0);

endmodule

// File: rtl/lp_fuse_array.sv
module lp_fuse_array #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DW       = 8,
  localparam int AW      = ROW_BITS + COL_BITS,
  localparam int BW      = $clog2(DW),
  localparam int ROW_W   = DW << COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [BW-1:0]       wr_bit,
  input  logic [ROW_BITS-1:0] rd_sel,
  output logic [ROW_W-1:0]    rd_row
);
  localparam int NROWS = 1 << ROW_BITS;
  localparam int IW    = BW + COL_BITS;

  logic [ROW_W-1:0]    fuse_q [NROWS];
  logic [ROW_BITS-1:0] wr_row;
  logic [IW-1:0]       wr_idx;
  logic [ROW_W-1:0]    set_mask;

  assign wr_row = wr_addr[AW-1:COL_BITS];
  // bit group k occupies columns [k*2^COL_BITS +: 2^COL_BITS]
  assign wr_idx = {wr_bit, wr_addr[COL_BITS-1:0]};

  always_comb begin
    set_mask = '0;
    set_mask[wr_idx] = 1'b1;
  end

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic             row_we;
    logic [ROW_W-1:0] row_nxt;

    assign row_we  = wr_en && (wr_row == ROW_BITS'(r));
    assign row_nxt = fuse_q[r] | set_mask;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fuse_q[r] <= '0;
      else if (row_we) fuse_q[r] <= row_nxt;
    end
  end

  assign rd_row = fuse_q[rd_sel];

endmodule

// File: rtl/lp_col_mux.sv
module lp_col_mux #(
  parameter int COL_BITS = 3,
  parameter int DW       = 8,
  localparam int ROW_W   = DW << COL_BITS
) (
  input  logic [ROW_W-1:0]    row,
  input  logic [COL_BITS-1:0] col,
  output logic [DW-1:0]       word
);
  localparam int NCOL = 1 << COL_BITS;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic [NCOL-1:0] grp;
    assign grp     = row[b*NCOL +: NCOL];
    assign word[b] = grp[col];
  end

endmodule

// File: rtl/latched_prom.sv
module latched_prom
  import latched_prom_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DW       = 8,
  parameter int LAT      = 2,
  localparam int AW      = ROW_BITS + COL_BITS,
  localparam int BW      = $clog2(DW),
  localparam int ROW_W   = DW << COL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic          pgm_mode,
  input  logic          pgm_req,
  input  logic [AW-1:0] pgm_addr,
  input  logic [BW-1:0] pgm_bit,
  output logic [DW-1:0] dout,
  output logic          dout_drive,
  output logic          dout_valid
);
  logic             cap;
  logic             active;
  logic             ready;
  logic [AW-1:0]    addr_q;
  logic [ROW_W-1:0] rd_row;
  logic [DW-1:0]    word;
  logic             pgm_ok;
  bus_mode_e        bus_mode;

  lp_edge_latch #(.AW(AW), .LAT(LAT)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .addr_in (addr_in),
    .cap     (cap),
    .addr_q  (addr_q),
    .active  (active),
    .ready   (ready)
  );

  // programming only while disabled and in program mode
  assign pgm_ok = pgm_req & pgm_mode & ce_n;

  lp_fuse_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pgm_ok),
    .wr_addr (pgm_addr),
    .wr_bit  (pgm_bit),
    .rd_sel  (addr_q[AW-1:COL_BITS]),
    .rd_row  (rd_row)
  );

  lp_col_mux #(.COL_BITS(COL_BITS), .DW(DW)) u_mux (
    .row  (rd_row),
    .col  (addr_q[COL_BITS-1:0]),
    .word (word)
  );

  always_comb bus_mode = decode_bus(ce_n, oe_n, active);

  assign dout_drive = (bus_mode == BUS_DRIVE);
  assign dout_valid = dout_drive & ready;
  assign dout       = dout_valid ? word : '0;

endmodule

// File: rtl/latched_prom_chk.sv
module latched_prom_chk #(
  parameter int AW    = 7,
  parameter int ROW_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             oe_n,
  input logic             pgm_mode,
  input logic             cap,
  input logic [AW-1:0]    addr_q,
  input logic [ROW_W-1:0] rd_row,
  input logic             dout_drive,
  input logic             dout_valid
);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_drive && !dout_valid));

  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (!dout_drive && !dout_valid));

  // R3
  valid_with_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_drive);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(addr_q));

  // R9
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !dout_valid);

  // R7
  no_unprogram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr_q) |-> (($past(rd_row) & ~rd_row) == '0));

  // R8
  pgm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pgm_mode && ce_n) && !cap) |=> $stable(rd_row));

endmodule

bind latched_prom latched_prom_chk #(.AW(AW), .ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .pgm_mode   (pgm_mode),
  .cap        (cap),
  .addr_q     (addr_q),
  .rd_row     (rd_row),
  .dout_drive (dout_drive),
  .dout_valid (dout_valid)
);

// File: tb/latched_prom_test.sv
`timescale 1ns/1ps
module latched_prom_test;
  localparam int RB  = 4;
  localparam int CB  = 3;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam int AW  = RB + CB;
  localparam int BW  = 3;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b0;
  logic          oe_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          pgm_mode = 1'b0;
  logic          pgm_req = 1'b0;
  logic [AW-1:0] pgm_addr = '0;
  logic [BW-1:0] pgm_bit = '0;
  logic [DW-1:0] dout;
  logic          dout_drive;
  logic          dout_valid;

  logic [DW-1:0] ref_mem [NW];
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  latched_prom #(.ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr_in(addr_in),
    .pgm_mode(pgm_mode), .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_bit(pgm_bit),
    .dout(dout), .dout_drive(dout_drive), .dout_valid(dout_valid)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic chk_out(input string what, input logic drv, input logic vld, input logic [DW-1:0] d);
    chk({what, " drive"}, 32'(dout_drive), 32'(drv));
    chk({what, " valid"}, 32'(dout_valid), 32'(vld));
    chk({what, " dout"},  32'(dout), 32'(d));
  endtask

  // program one cell; ce selects whether ce_n is raised first
  task automatic pgm(input int a, input int b, input logic mode, input logic ce);
    @(negedge clk);
    if (ce) ce_n = 1'b1;
    pgm_mode = mode; pgm_req = 1'b1;
    pgm_addr = AW'(a); pgm_bit = BW'(b);
    if (mode && ce_n) ref_mem[a][b] = 1'b1;
    @(negedge clk);
    pgm_req = 1'b0; pgm_mode = 1'b0;
  endtask

  // raise enable, then lower it with the address; returns at the negedge after capture
  task automatic start_read(input int a);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b0; addr_in = AW'(a);
    @(negedge clk);
  endtask

  task automatic read_chk(input int a, input string what);
    start_read(a);
    repeat (LAT) @(negedge clk);
    chk_out(what, 1'b1, 1'b1, ref_mem[a]);
  endtask

  task automatic t_reset;
    ce_n = 1'b0; oe_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out("R6 held low from reset", 1'b0, 1'b0, '0);
  endtask

  task automatic t_blank;
    read_chk(5, "R7 blank word 5");
    read_chk(NW - 1, "R7 blank top word");
  endtask

  task automatic t_latency;
    pgm(9, 4, 1'b1, 1'b1);
    start_read(9);
    chk_out("R9 after capture edge", 1'b1, 1'b0, '0);
    @(negedge clk);
    chk_out("R9 one edge later", 1'b1, 1'b0, '0);
    @(negedge clk);
    chk_out("R3 R9 valid at LAT", 1'b1, 1'b1, 8'h10);
  endtask

  task automatic t_program;
    pgm(0, 0, 1'b1, 1'b1);
    pgm(7, 7, 1'b1, 1'b1);
    pgm(8, 3, 1'b1, 1'b1);
    pgm(69, 1, 1'b1, 1'b1);
    pgm(69, 6, 1'b1, 1'b1);
    pgm(127, 0, 1'b1, 1'b1);
    pgm(127, 7, 1'b1, 1'b1);
    read_chk(0, "R10 word 0 bit0");
    chk("R10 word 0 value", 32'(dout), 32'h01);
    read_chk(7, "R10 word 7 bit7");
    chk("R10 word 7 value", 32'(dout), 32'h80);
    read_chk(8, "R10 word 8 bit3 next row");
    chk("R10 word 8 value", 32'(dout), 32'h08);
    read_chk(69, "R7 word 69 two cells");
    chk("R7 word 69 value", 32'(dout), 32'h42);
    read_chk(1, "R10 neighbour word 1 untouched");
    chk("R10 word 1 value", 32'(dout), 32'h00);
  endtask

  task automatic t_no_clear;
    pgm(69, 6, 1'b1, 1'b1);
    pgm(69, 3, 1'b1, 1'b1);
    read_chk(69, "R7 reprogram keeps cells");
    chk("R7 word 69 after more cells", 32'(dout), 32'h4A);
  endtask

  task automatic t_pgm_ignored;
    pgm(16, 2, 1'b0, 1'b1);
    read_chk(16, "R8 no program mode");
    chk("R8 word 16 value", 32'(dout), 32'h00);
    start_read(17);
    repeat (LAT) @(negedge clk);
    pgm(17, 4, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R8 program with ce low during read", 1'b1, 1'b1, 8'h00);
    read_chk(17, "R8 word 17 after rejected program");
  endtask

  task automatic t_latch;
    start_read(69);
    addr_in = AW'(7);
    repeat (LAT) @(negedge clk);
    chk_out("R2 address change ignored", 1'b1, 1'b1, ref_mem[69]);
    addr_in = AW'(127);
    repeat (3) @(negedge clk);
    chk_out("R6 held low no recapture", 1'b1, 1'b1, ref_mem[69]);
    read_chk(7, "R6 new access after high");
  endtask

  task automatic t_oe;
    read_chk(127, "R3 word 127");
    oe_n = 1'b1; #1;
    chk_out("R4 oe high", 1'b0, 1'b0, '0);
    @(negedge clk);
    chk_out("R4 oe high held", 1'b0, 1'b0, '0);
    oe_n = 1'b0; #1;
    chk_out("R4 oe back low", 1'b1, 1'b1, 8'h81);
    ce_n = 1'b1; #1;
    chk_out("R5 ce high oe low", 1'b0, 1'b0, '0);
    oe_n = 1'b1; #1;
    chk_out("R5 ce high oe high", 1'b0, 1'b0, '0);
    @(negedge clk);
    chk_out("R5 ce high clocked", 1'b0, 1'b0, '0);
    oe_n = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    t_reset();
    t_blank();
    t_latency();
    t_program();
    t_no_clear();
    t_pgm_ignored();
    t_latch();
    t_oe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule